// File: doc/BRIEF.md
# Buffered PWM Down-Counter Timer

This block generates one pulse-width-modulated output from a down counter. Software places a period value and a duty value in two separate holding registers. The counter takes the period value when the timer starts and again each time it wraps below zero. The duty value moves into its active copy only at a wrap. A new pair of values therefore never disturbs a period that is already in progress. The counter steps once for each count-enable tick from an external prescaler.

A start comes from a software trigger pulse or from an external trigger pulse. The external pulse has already been edge-detected and is gated by its own enable input. The timer then runs either continuously or for a single period. The output is low from each reload until the count reaches the active duty value, and high from there to the wrap. This waveform can be inverted, or forced to its inactive level by a mask input. Three one-cycle event strobes (start accepted, duty point reached, wrap) feed a status block that lives elsewhere.

Top module: `pwm_down_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `busy` is 0, `count_val` is 0, the active duty value and both holding registers are 0, and all three event strobes are 0.
- R2: A high `cyc_wr` (or `duty_wr`) at a clock edge stores the write data into the period (or duty) holding register. The write changes neither `count_val` nor `busy`.
- R3: A trigger is `sw_trig`, or `ext_trig` while `ext_trig_en` is 1. A trigger is accepted when `run_en` is 1 and the timer is stopped. One cycle after an accepted trigger, `busy` is 1, `count_val` equals the period holding register, and `evt_trig` is high for one cycle. `ext_trig` has no effect while `ext_trig_en` is 0.
- R4: While `busy` is 1 and no trigger is accepted, each cycle with `cnt_tick` high and `count_val` nonzero lowers `count_val` by one in the next cycle. While the timer is stopped, `cnt_tick` has no effect on `count_val`.
- R5: A tick at count 0 while running is the wrap. One cycle later `evt_udf` is high for one cycle, and the active duty value takes the duty holding register. In continuous mode `count_val` takes the period holding register.
- R6: With `oneshot` at 1, the wrap stops the timer: `busy` becomes 0 and `count_val` shows 0xFFFF. With `oneshot` at 0, the timer keeps running.
- R7: With `pol_inv` 0 and `out_mask` 0, `pwm_out` is 1 exactly when `busy` is 1 and `count_val` is less than or equal to the active duty value. A duty value equal to the period value gives a period that is high throughout. The duty value must not exceed the period value; the bench never applies that case.
- R8: With `pol_inv` 1, `pwm_out` is the complement of the R7 level. When the timer is stopped and unmasked, `pwm_out` equals `pol_inv`.
- R9: With `out_mask` 1, `pwm_out` equals `pol_inv` (low for normal polarity, high for inverted), whatever the count and duty values are.
- R10: A trigger arriving while `busy` is 1 reloads the counter from the period holding register and raises `evt_trig` only when `restart_en` is 1. Otherwise the trigger is ignored and counting goes on.
- R11: `run_en` at 0 at a clock edge makes `busy` 0 after that edge and holds `count_val`. Triggers seen while `run_en` is 0 are ignored.
- R12: `evt_duty` is high for one cycle, while `busy` is 1, in the first cycle in which `count_val` equals the active duty value after a reload or a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Count enable level; 0 stops the timer |
| oneshot | input | 1 | 1 selects one-shot, 0 selects continuous |
| restart_en | input | 1 | Lets a trigger restart a running timer |
| sw_trig | input | 1 | Software trigger pulse |
| ext_trig | input | 1 | External trigger pulse, already edge-detected |
| ext_trig_en | input | 1 | Enables the external trigger |
| cnt_tick | input | 1 | Count-enable tick from the prescaler |
| pol_inv | input | 1 | 1 inverts the output polarity |
| out_mask | input | 1 | 1 forces the output to its inactive level |
| cyc_wr | input | 1 | Write strobe for the period holding register |
| cyc_wdata | input | CW | Period write data |
| duty_wr | input | 1 | Write strobe for the duty holding register |
| duty_wdata | input | CW | Duty write data |
| pwm_out | output | 1 | PWM waveform |
| busy | output | 1 | Timer is counting |
| count_val | output | CW | Present counter value |
| evt_trig | output | 1 | Start/restart accepted strobe |
| evt_duty | output | 1 | Duty point reached strobe |
| evt_udf | output | 1 | Wrap strobe |

## Verification
The counter, `busy` and all three event strobes are registered. Each one therefore reflects, one clock after the edge, the inputs that were present at that edge. `pwm_out` is derived without a register from that registered state and from the live `pol_inv` and `out_mask` levels, so it changes in the same cycle as they do. The bench changes inputs just after a falling edge and compares every output with its reference model at the next falling edge. By then exactly one rising edge has passed, so a start, a tick or a wrap is checked in the cycle right after it. Mask and polarity changes are checked a nanosecond after they are applied, before the next rising edge.

// File: rtl/pwm_tmr_pkg.sv
// Shared types for the buffered PWM down-counter timer.
// Assumes: nothing beyond the consumers importing it.
package pwm_tmr_pkg;

    // One-cycle event strobes produced by the counter core.
    typedef struct packed {
        logic trig;
        logic duty;
        logic udf;
    } pwm_evt_t;

    // Counter action chosen for the coming clock edge.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_STOP  = 3'd1,
        ACT_START = 3'd2,
        ACT_DEC   = 3'd3,
        ACT_WRAP  = 3'd4
    } cnt_act_e;

endpackage

// File: rtl/pwm_buf_regs.sv
// Holding registers for the period and duty values.
// Two identical write-strobed registers, built by a generate loop.
// Assumes: writes are single-cycle strobes; reset clears both to 0.
module pwm_buf_regs #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_wr,
    input  logic [CW-1:0] cyc_wdata,
    input  logic          duty_wr,
    input  logic [CW-1:0] duty_wdata,
    output logic [CW-1:0] cyc_buf,
    output logic [CW-1:0] duty_buf
);
    localparam int NBUF = 2;

    logic          wr_v [NBUF];
    logic [CW-1:0] wd_v [NBUF];
    logic [CW-1:0] q_v  [NBUF];

    // Pack the two write ports into arrays indexed by register.
    always_comb begin
        wr_v[0] = cyc_wr;
        wd_v[0] = cyc_wdata;
        wr_v[1] = duty_wr;
        wd_v[1] = duty_wdata;
    end

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        // Capture the write data whenever this register's strobe is high.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_v[i] <= '0;
            else if (wr_v[i])
                q_v[i] <= wd_v[i];
        end
    end

    assign cyc_buf  = q_v[0];
    assign duty_buf = q_v[1];

endmodule

// File: rtl/pwm_seq_ctrl.sv
// Sequencing decision for the timer: picks one counter action per cycle.
// Priority: enable low stops; an accepted trigger starts/restarts;
// a tick while running decrements or wraps; otherwise hold.
// Assumes: trigger inputs are already single-cycle pulses.
module pwm_seq_ctrl
    import pwm_tmr_pkg::*;
(
    input  logic     run_en,
    input  logic     sw_trig,
    input  logic     ext_trig,
    input  logic     ext_trig_en,
    input  logic     restart_en,
    input  logic     busy,
    input  logic     cnt_tick,
    input  logic     cnt_zero,
    output cnt_act_e act
);
    logic trig_any;
    logic trig_ok;

    // Merge trigger sources and decide whether a trigger is accepted.
    always_comb begin
        trig_any = run_en & (sw_trig | (ext_trig & ext_trig_en));
        trig_ok  = trig_any & (~busy | restart_en);
    end

    // Select the counter action for this edge by fixed priority.
    always_comb begin
        if (!run_en)
            act = ACT_STOP;
        else if (trig_ok)
            act = ACT_START;
        else if (busy && cnt_tick)
            act = cnt_zero ? ACT_WRAP : ACT_DEC;
        else
            act = ACT_HOLD;
    end

endmodule

// File: rtl/pwm_count_core.sv
// Down counter, run flag, active duty copy and event strobes.
// Start loads the period buffer; a wrap loads period and duty buffers
// (one-shot wrap stops and leaves the all-ones wrap value visible).
// Assumes: the action input is already prioritised.
module pwm_count_core
    import pwm_tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_act_e      act,
    input  logic          oneshot,
    input  logic [CW-1:0] cyc_buf,
    input  logic [CW-1:0] duty_buf,
    output logic          busy,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] act_duty,
    output pwm_evt_t      evt
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic          busy_n;
    logic [CW-1:0] cnt_n;
    logic [CW-1:0] duty_n;
    pwm_evt_t      evt_n;
    logic          moved;

    // Next-state computation for counter, run flag, duty copy and strobes.
    always_comb begin
        busy_n     = busy;
        cnt_n      = cnt;
        duty_n     = act_duty;
        evt_n      = '0;
        moved      = 1'b0;
        case (act)
            ACT_STOP: begin
                busy_n = 1'b0;
            end
            ACT_START: begin
                busy_n     = 1'b1;
                cnt_n      = cyc_buf;
                evt_n.trig = 1'b1;
                moved      = 1'b1;
            end
            ACT_DEC: begin
                cnt_n = cnt - ONE;
                moved = 1'b1;
            end
            ACT_WRAP: begin
                evt_n.udf = 1'b1;
                duty_n    = duty_buf;
                moved     = 1'b1;
                if (oneshot) begin
                    busy_n = 1'b0;
                    cnt_n  = '1;
                end else begin
                    cnt_n  = cyc_buf;
                end
            end
            default: begin
                busy_n = busy;
            end
        endcase
        evt_n.duty = moved & busy_n & (cnt_n == duty_n);
    end

    // Register the state and the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            act_duty <= '0;
            evt      <= '0;
        end else begin
            busy     <= busy_n;
            cnt      <= cnt_n;
            act_duty <= duty_n;
            evt      <= evt_n;
        end
    end

endmodule

// File: rtl/pwm_out_stage.sv
// Output shaping: band compare, polarity and mask.
// Assumes: active duty never exceeds the period value loaded.
module pwm_out_stage #(
    parameter int CW = 16
) (
    input  logic          busy,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] act_duty,
    input  logic          pol_inv,
    input  logic          out_mask,
    output logic          pwm_out
);
    logic in_band;

    // Active phase is the tail of the period, from the duty point to the wrap.
    always_comb begin
        in_band = busy & (cnt <= act_duty);
        pwm_out = out_mask ? pol_inv : (in_band ^ pol_inv);
    end

endmodule

// File: rtl/pwm_down_timer.sv
// Top of the buffered PWM down-counter timer.
// Connects holding registers, sequencing decision, counter core and
// output stage. Assumes: cnt_tick comes from a prescaler in this clock
// domain; triggers are pre-edge-detected pulses.
module pwm_down_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          oneshot,
    input  logic          restart_en,
    input  logic          sw_trig,
    input  logic          ext_trig,
    input  logic          ext_trig_en,
    input  logic          cnt_tick,
    input  logic          pol_inv,
    input  logic          out_mask,
    input  logic          cyc_wr,
    input  logic [CW-1:0] cyc_wdata,
    input  logic          duty_wr,
    input  logic [CW-1:0] duty_wdata,
    output logic          pwm_out,
    output logic          busy,
    output logic [CW-1:0] count_val,
    output logic          evt_trig,
    output logic          evt_duty,
    output logic          evt_udf
);
    logic [CW-1:0] cyc_buf;
    logic [CW-1:0] duty_buf;
    logic [CW-1:0] act_duty;
    logic          cnt_zero;
    cnt_act_e      act;
    pwm_evt_t      evt;

    pwm_buf_regs #(.CW(CW)) u_bufs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_wr     (cyc_wr),
        .cyc_wdata  (cyc_wdata),
        .duty_wr    (duty_wr),
        .duty_wdata (duty_wdata),
        .cyc_buf    (cyc_buf),
        .duty_buf   (duty_buf)
    );

    // Zero detect feeding the wrap decision.
    assign cnt_zero = (count_val == '0);

    pwm_seq_ctrl u_seq (
        .run_en      (run_en),
        .sw_trig     (sw_trig),
        .ext_trig    (ext_trig),
        .ext_trig_en (ext_trig_en),
        .restart_en  (restart_en),
        .busy        (busy),
        .cnt_tick    (cnt_tick),
        .cnt_zero    (cnt_zero),
        .act         (act)
    );

    pwm_count_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .oneshot  (oneshot),
        .cyc_buf  (cyc_buf),
        .duty_buf (duty_buf),
        .busy     (busy),
        .cnt      (count_val),
        .act_duty (act_duty),
        .evt      (evt)
    );

    pwm_out_stage #(.CW(CW)) u_out (
        .busy     (busy),
        .cnt      (count_val),
        .act_duty (act_duty),
        .pol_inv  (pol_inv),
        .out_mask (out_mask),
        .pwm_out  (pwm_out)
    );

    // Expose the event strobes.
    assign evt_trig = evt.trig;
    assign evt_duty = evt.duty;
    assign evt_udf  = evt.udf;

endmodule

// File: rtl/pwm_down_timer_chk.sv
// Property checker for pwm_down_timer, attached by bind below.
// Assumes: synchronous active-low reset, as in the design.
module pwm_down_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          oneshot,
    input logic          restart_en,
    input logic          sw_trig,
    input logic          ext_trig,
    input logic          ext_trig_en,
    input logic          cnt_tick,
    input logic          pol_inv,
    input logic          out_mask,
    input logic          pwm_out,
    input logic          busy,
    input logic [CW-1:0] count_val,
    input logic          evt_trig,
    input logic          evt_duty,
    input logic          evt_udf,
    input logic [CW-1:0] cyc_buf
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic trig_any;
    assign trig_any = run_en & (sw_trig | (ext_trig & ext_trig_en));

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && count_val == '0 && !evt_trig && !evt_duty && !evt_udf)); // R1
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n) evt_trig |-> (busy && count_val == $past(cyc_buf))); // R3
    AST_TRIG_UDF_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(evt_trig && evt_udf)); // R3
    AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n) (busy && run_en && cnt_tick && !trig_any && count_val != '0) |=> (count_val == $past(count_val) - ONE)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !trig_any) |=> ($stable(count_val) && !busy)); // R4
    AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) evt_udf |-> ($past(count_val) == '0 && $past(cnt_tick) && $past(busy))); // R5
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n) (evt_udf && $past(oneshot)) |-> (!busy && count_val == '1)); // R6
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !out_mask) |-> (pwm_out == pol_inv)); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (evt_trig && $past(busy)) |-> $past(restart_en)); // R10
    AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n) !run_en |=> !busy); // R11
    AST_DUTY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) evt_duty |-> busy); // R12

endmodule

bind pwm_down_timer pwm_down_timer_chk #(.CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .oneshot     (oneshot),
    .restart_en  (restart_en),
    .sw_trig     (sw_trig),
    .ext_trig    (ext_trig),
    .ext_trig_en (ext_trig_en),
    .cnt_tick    (cnt_tick),
    .pol_inv     (pol_inv),
    .out_mask    (out_mask),
    .pwm_out     (pwm_out),
    .busy        (busy),
    .count_val   (count_val),
    .evt_trig    (evt_trig),
    .evt_duty    (evt_duty),
    .evt_udf     (evt_udf),
    .cyc_buf     (cyc_buf)
);

// File: tb/pwm_down_timer_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared each cycle against a reference model built from the brief.
module pwm_down_timer_tb_top;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run_en, oneshot, restart_en, sw_trig, ext_trig, ext_trig_en;
    logic          cnt_tick, pol_inv, out_mask, cyc_wr, duty_wr;
    logic [CW-1:0] cyc_wdata, duty_wdata;
    logic          pwm_out, busy, evt_trig, evt_duty, evt_udf;
    logic [CW-1:0] count_val;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model state
    logic          m_busy = 1'b0;
    logic [CW-1:0] m_cnt = '0, m_duty = '0, m_cb = '0, m_db = '0;
    logic          m_et = 1'b0, m_ed = 1'b0, m_eu = 1'b0;

    pwm_down_timer #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .oneshot(oneshot),
        .restart_en(restart_en), .sw_trig(sw_trig), .ext_trig(ext_trig),
        .ext_trig_en(ext_trig_en), .cnt_tick(cnt_tick), .pol_inv(pol_inv),
        .out_mask(out_mask), .cyc_wr(cyc_wr), .cyc_wdata(cyc_wdata),
        .duty_wr(duty_wr), .duty_wdata(duty_wdata), .pwm_out(pwm_out),
        .busy(busy), .count_val(count_val), .evt_trig(evt_trig),
        .evt_duty(evt_duty), .evt_udf(evt_udf)
    );

    always #10 clk = ~clk;

    // Expected waveform level (R7, R8, R9).
    function automatic logic exp_pwm(logic b, logic [CW-1:0] c, logic [CW-1:0] d,
                                     logic inv, logic msk);
        if (msk) return inv;
        return (b && (c <= d)) ^ inv;
    endfunction

    // Reference model, advanced at each rising edge from the stable inputs.
    always @(posedge clk) begin
        logic tg, acc;
        m_et = 1'b0; m_ed = 1'b0; m_eu = 1'b0;
        if (!rst_n) begin
            m_busy = 1'b0; m_cnt = '0; m_duty = '0; m_cb = '0; m_db = '0;
        end else begin
            tg  = run_en && (sw_trig || (ext_trig && ext_trig_en));
            acc = tg && (!m_busy || restart_en);
            if (!run_en) begin
                m_busy = 1'b0;
            end else if (acc) begin
                m_busy = 1'b1; m_cnt = m_cb; m_et = 1'b1;
                m_ed = (m_cnt == m_duty);
            end else if (m_busy && cnt_tick) begin
                if (m_cnt == '0) begin
                    m_eu = 1'b1; m_duty = m_db;
                    if (oneshot) begin
                        m_busy = 1'b0; m_cnt = '1;
                    end else begin
                        m_cnt = m_cb;
                        m_ed = (m_cnt == m_duty);
                    end
                end else begin
                    m_cnt = m_cnt - 1'b1;
                    m_ed = (m_cnt == m_duty);
                end
            end
            if (cyc_wr)  m_cb = cyc_wdata;
            if (duty_wr) m_db = duty_wdata;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic cmp_all();
        string rq;
        rq = out_mask ? "R9" : (pol_inv ? "R8" : "R7");
        chk("R4", "count_val", 32'(count_val), 32'(m_cnt));
        chk("R6", "busy", 32'(busy), 32'(m_busy));
        chk("R3", "evt_trig", 32'(evt_trig), 32'(m_et));
        chk("R5", "evt_udf", 32'(evt_udf), 32'(m_eu));
        chk("R12", "evt_duty", 32'(evt_duty), 32'(m_ed));
        chk(rq, "pwm_out", 32'(pwm_out),
            32'(exp_pwm(m_busy, m_cnt, m_duty, pol_inv, out_mask)));
    endtask

    // Advance one cycle, compare, then drop single-cycle pulses.
    task automatic cyc();
        @(negedge clk);
        cmp_all();
        sw_trig = 1'b0; ext_trig = 1'b0; cyc_wr = 1'b0; duty_wr = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        logic [CW-1:0] hold;
        int c;
        void'($urandom(32'd4242));
        rst_n = 1'b0; run_en = 1'b0; oneshot = 1'b0; restart_en = 1'b0;
        sw_trig = 1'b0; ext_trig = 1'b0; ext_trig_en = 1'b0; cnt_tick = 1'b0;
        pol_inv = 1'b0; out_mask = 1'b0; cyc_wr = 1'b0; duty_wr = 1'b0;
        cyc_wdata = '0; duty_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy after reset", 32'(busy), 0);
        chk("R1", "count after reset", 32'(count_val), 0);
        chk("R1", "events after reset", 32'({evt_trig, evt_duty, evt_udf}), 0);
        chk("R1", "idle level normal", 32'(pwm_out), 0);
        pol_inv = 1'b1; #1;
        chk("R8", "idle level inverted", 32'(pwm_out), 1);
        pol_inv = 1'b0;
        rst_n = 1'b1; run_en = 1'b1; cnt_tick = 1'b1;

        // R2 buffer write does not touch the counter
        cyc_wr = 1'b1; cyc_wdata = 16'd5; duty_wr = 1'b1; duty_wdata = 16'd5;
        cyc();
        chk("R2", "count untouched by write", 32'(count_val), 0);
        chk("R2", "still stopped after write", 32'(busy), 0);

        // R3 software start
        sw_trig = 1'b1;
        cyc();
        chk("R3", "start loads period", 32'(count_val), 5);
        chk("R3", "start strobe", 32'(evt_trig), 1);

        // R5 wrap, then R7 duty == period gives a full-high period
        for (int i = 0; i < 20 && !evt_udf; i++) cyc();
        chk("R5", "wrap strobe", 32'(evt_udf), 1);
        chk("R5", "wrap reloads period", 32'(count_val), 5);
        for (int i = 0; i < 6; i++) begin
            chk("R7", "high through whole period", 32'(pwm_out), 1);
            cyc();
        end

        // R9 mask under both polarities
        out_mask = 1'b1; #1;
        chk("R9", "mask normal", 32'(pwm_out), 0);
        pol_inv = 1'b1; #1;
        chk("R9", "mask inverted", 32'(pwm_out), 1);
        out_mask = 1'b0; pol_inv = 1'b0;
        duty_wr = 1'b1; duty_wdata = 16'd2;
        cyc();

        // R10 trigger while running, restart off then on
        for (int i = 0; i < 20 && count_val != 16'd3; i++) cyc();
        restart_en = 1'b0; sw_trig = 1'b1;
        cyc();
        chk("R10", "ignored trigger keeps counting", 32'(count_val), 2);
        chk("R10", "ignored trigger no strobe", 32'(evt_trig), 0);
        restart_en = 1'b1; ext_trig_en = 1'b1; ext_trig = 1'b1;
        cyc();
        chk("R10", "restart reloads period", 32'(count_val), 5);
        chk("R10", "restart strobe", 32'(evt_trig), 1);

        // R11 disable stops, triggers ignored while disabled
        run_en = 1'b0;
        cyc();
        chk("R11", "stopped by enable low", 32'(busy), 0);
        hold = count_val;
        sw_trig = 1'b1;
        cyc();
        chk("R11", "trigger ignored while disabled", 32'(busy), 0);
        chk("R11", "count held while disabled", 32'(count_val), 32'(hold));
        chk("R11", "no strobe while disabled", 32'(evt_trig), 0);
        chk("R11", "idle level while stopped", 32'(pwm_out), 0);

        // R6 one-shot stops at wrap
        run_en = 1'b1; oneshot = 1'b1; ext_trig_en = 1'b0;
        cyc();
        sw_trig = 1'b1;
        cyc();
        for (int i = 0; i < 20 && !evt_udf; i++) cyc();
        chk("R6", "one-shot stops at wrap", 32'(busy), 0);
        chk("R6", "one-shot shows wrap value", 32'(count_val), 32'hFFFF);
        cyc();
        chk("R6", "one-shot stays stopped", 32'(busy), 0);
        ext_trig = 1'b1;
        cyc();
        chk("R3", "external trigger gated off", 32'(busy), 0);
        ext_trig_en = 1'b1; ext_trig = 1'b1;
        cyc();
        chk("R3", "external trigger starts", 32'(busy), 1);
        chk("R3", "external start strobe", 32'(evt_trig), 1);
        oneshot = 1'b0;

        // Seeded random traffic in blocks with fixed mode settings
        for (int b = 0; b < 12; b++) begin
            oneshot     = ($urandom % 3) == 0;
            restart_en  = $urandom % 2;
            ext_trig_en = $urandom % 2;
            pol_inv     = $urandom % 2;
            out_mask    = ($urandom % 5) == 0;
            for (int k = 0; k < 250; k++) begin
                cnt_tick = ($urandom % 2) == 0;
                sw_trig  = ($urandom % 40) == 0;
                ext_trig = ($urandom % 40) == 0;
                run_en   = ($urandom % 150) != 0;
                if (($urandom % 25) == 0) begin
                    c = $urandom % 13;
                    cyc_wr = 1'b1; cyc_wdata = 16'(c);
                    duty_wr = 1'b1; duty_wdata = 16'($urandom % (c + 1));
                end
                cyc();
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule